// File: doc/BRIEF.md
# Dual-Mode Pixel Output Formatter

This block sits at the end of a display link receiver. It takes decoded pixels, one per dot clock at most, and places them on a wide parallel output bus for a panel. Each pixel carries 18 bits of colour, two sync bits and four control bits. In single mode each pixel goes straight to the output. In paired mode two pixels leave together, so the panel can capture them with a shift clock at half the dot rate.

A shift-clock enable is produced beside the data. In paired mode it toggles so that the capture edge falls in the middle of the two-cycle data window. A polarity input chooses whether that edge rises or falls. Two static force inputs drive every output low or high for board testing. A reserved panel-size code blanks the outputs and raises an error flag.

Top module: `pix_out_fmt`

## Requirements
- R1: While rst_n is low, and at the first edge after it, every output is low and no half pair is held.
- R2: With one_ppc high, a pixel accepted at an edge appears on port1 after that edge. Every bit of port0 is then high, the syncs and controls follow that pixel, and sclk_en is 1. sclk_en is 0 after any edge without a pixel. The colour field layout is red in bits 17:12, green in bits 11:6 and blue in bits 5:0, and it passes through unchanged.
- R3: With one_ppc low, pixels are grouped in arrival order. The first pixel of a pair is held. On the edge that accepts the second pixel, port0 takes the first pixel and port1 takes the second.
- R4: In paired mode the syncs and controls come from the second pixel of the pair. All data outputs hold their values between emitted pairs.
- R5: A change of one_ppc drops any held half pair, which is never emitted. A pixel that arrives in the same cycle as the change starts a new pair.
- R6: panel_sel = 2'b11 is reserved. After an edge where it is present, every data output and sclk_en are low, panel_err is high, and any half pair is dropped. Once a valid code is present, panel_err is low after the next edge, and the outputs hold until the next emitted pixel.
- R7: force_lo drives every output low, panel_err included, after the next edge. It takes priority over everything else and drops any half pair.
- R8: force_hi with force_lo low drives every output high, panel_err included, after the next edge. It also drops any half pair.
- R9: In paired mode, sclk_en equals sclk_fall after an edge that emits a pair and equals its inverse after any other edge. With sclk_fall = 0 the enable therefore rises one dot cycle into each data window, and with sclk_fall = 1 it falls there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dot_clk | input | 1 | Dot clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | A pixel is presented this cycle |
| pix_rgb | input | 18 | Pixel colour {red, green, blue}, 6 bits each |
| pix_hs | input | 1 | Horizontal sync with the pixel |
| pix_vs | input | 1 | Vertical sync with the pixel |
| pix_ctl | input | 4 | Control bits with the pixel |
| one_ppc | input | 1 | 1: one pixel per shift clock; 0: two |
| panel_sel | input | 2 | Panel size code; 2'b11 reserved |
| sclk_fall | input | 1 | 1: capture on the falling edge of the shift clock |
| force_lo | input | 1 | Test: all outputs low |
| force_hi | input | 1 | Test: all outputs high |
| port0 | output | 18 | Earlier pixel of a pair; all ones in single mode |
| port1 | output | 18 | Single pixel, or later pixel of a pair |
| hsync_o | output | 1 | Horizontal sync out |
| vsync_o | output | 1 | Vertical sync out |
| ctl_o | output | 4 | Control bits out |
| sclk_en | output | 1 | Shift-clock enable / phase |
| panel_err | output | 1 | Reserved panel code present |

## Verification
Every result of the block is due exactly one dot-clock edge after the inputs that cause it. This holds for a single pixel, for the second pixel of a pair, for a force, and for a panel code change. The bench drives inputs on the falling edge. It advances its own model by the same inputs, then compares all outputs at the next falling edge, half a period after the update. A held half pair makes no output change in the cycle it is stored. The bench therefore checks that the outputs hold there and that the pair appears only one edge after its second pixel.

// File: rtl/pix_out_fmt.sv
module pix_out_fmt #(
  parameter int CW   = 6,
  parameter int NCTL = 4
) (
  input  logic            dot_clk,
  input  logic            rst_n,
  input  logic            pix_valid,
  input  logic [3*CW-1:0] pix_rgb,
  input  logic            pix_hs,
  input  logic            pix_vs,
  input  logic [NCTL-1:0] pix_ctl,
  input  logic            one_ppc,
  input  logic [1:0]      panel_sel,
  input  logic            sclk_fall,
  input  logic            force_lo,
  input  logic            force_hi,
  output logic [3*CW-1:0] port0,
  output logic [3*CW-1:0] port1,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic [NCTL-1:0] ctl_o,
  output logic            sclk_en,
  output logic            panel_err
);
  localparam int PW = 3*CW;

  logic [PW-1:0] first_q;
  logic          have_q, mode_q;

  wire bad_code = (panel_sel == 2'b11);
  wire mode_chg = (one_ppc != mode_q);
  wire pair_out = !one_ppc && pix_valid && have_q && !mode_chg;

  always_ff @(posedge dot_clk) begin
    if (!rst_n) begin
      port0 <= '0; port1 <= '0; hsync_o <= 1'b0; vsync_o <= 1'b0;
      ctl_o <= '0; sclk_en <= 1'b0; panel_err <= 1'b0;
      first_q <= '0; have_q <= 1'b0; mode_q <= 1'b1;
    end else begin
      mode_q <= one_ppc;
      if (force_lo || force_hi || bad_code) begin
        port0   <= {PW{force_hi && !force_lo}};
        port1   <= {PW{force_hi && !force_lo}};
        hsync_o <= force_hi && !force_lo;
        vsync_o <= force_hi && !force_lo;
        ctl_o   <= {NCTL{force_hi && !force_lo}};
        sclk_en <= force_hi && !force_lo;
        panel_err <= !force_lo;
        have_q  <= 1'b0;
      end else begin
        panel_err <= 1'b0;
        if (one_ppc) begin
          sclk_en <= pix_valid;
          have_q  <= 1'b0;
          if (pix_valid) begin
            port0 <= '1; port1 <= pix_rgb;
            hsync_o <= pix_hs; vsync_o <= pix_vs; ctl_o <= pix_ctl;
          end
        end else begin
          sclk_en <= pair_out ? sclk_fall : !sclk_fall;
          if (pair_out) begin
            port0 <= first_q; port1 <= pix_rgb;
            hsync_o <= pix_hs; vsync_o <= pix_vs; ctl_o <= pix_ctl;
            have_q <= 1'b0;
          end else if (pix_valid) begin
            first_q <= pix_rgb;
            have_q  <= 1'b1;
          end else if (mode_chg) begin
            have_q <= 1'b0;
          end
        end
      end
    end
  end
endmodule

module pix_out_fmt_chk #(
  parameter int PW = 18
) (
  input logic          dot_clk,
  input logic          rst_n,
  input logic          pix_valid,
  input logic [PW-1:0] pix_rgb,
  input logic          one_ppc,
  input logic [1:0]    panel_sel,
  input logic          sclk_fall,
  input logic          force_lo,
  input logic          force_hi,
  input logic [PW-1:0] port0,
  input logic [PW-1:0] port1,
  input logic          sclk_en,
  input logic          panel_err
);
  wire normal = !force_lo && !force_hi && panel_sel != 2'b11;

  p_single_r2: assert property (@(posedge dot_clk) disable iff (!rst_n)
    (normal && one_ppc && pix_valid) |=> (port1 == $past(pix_rgb) && (&port0) && sclk_en));

  p_hold_r4: assert property (@(posedge dot_clk) disable iff (!rst_n)
    (normal && !one_ppc && !pix_valid) |=> ($stable(port0) && $stable(port1) && sclk_en == !$past(sclk_fall)));

  p_badcode_r6: assert property (@(posedge dot_clk) disable iff (!rst_n)
    (!force_lo && !force_hi && panel_sel == 2'b11) |=> (panel_err && port0 == '0 && port1 == '0 && !sclk_en));

  p_forcelo_r7: assert property (@(posedge dot_clk) disable iff (!rst_n)
    force_lo |=> (!panel_err && port0 == '0 && port1 == '0 && !sclk_en));

  p_forcehi_r8: assert property (@(posedge dot_clk) disable iff (!rst_n)
    (force_hi && !force_lo) |=> (panel_err && (&port0) && (&port1) && sclk_en));
endmodule

bind pix_out_fmt pix_out_fmt_chk #(.PW(PW)) u_chk (
  .dot_clk(dot_clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_rgb(pix_rgb),
  .one_ppc(one_ppc), .panel_sel(panel_sel), .sclk_fall(sclk_fall),
  .force_lo(force_lo), .force_hi(force_hi), .port0(port0), .port1(port1),
  .sclk_en(sclk_en), .panel_err(panel_err)
);

// File: tb/sim_pix_out_fmt.sv
`timescale 1ns/1ps
module sim_pix_out_fmt;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pv = 1'b0, hs = 1'b0, vs = 1'b0, one = 1'b1, fall = 1'b0, flo = 1'b0, fhi = 1'b0;
  logic [17:0] rgb = '0;
  logic [3:0] ctl = '0;
  logic [1:0] psel = 2'b00;
  logic [17:0] p0, p1;
  logic ho, vo, sc, err;
  logic [3:0] co;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pix_out_fmt u0 (
    .dot_clk(clk), .rst_n(rst_n), .pix_valid(pv), .pix_rgb(rgb), .pix_hs(hs),
    .pix_vs(vs), .pix_ctl(ctl), .one_ppc(one), .panel_sel(psel), .sclk_fall(fall),
    .force_lo(flo), .force_hi(fhi), .port0(p0), .port1(p1), .hsync_o(ho),
    .vsync_o(vo), .ctl_o(co), .sclk_en(sc), .panel_err(err)
  );

  // reference model state
  logic [17:0] e0 = '0, e1 = '0, m_first = '0;
  logic eh = 0, ev = 0, es = 0, ee = 0, m_have = 0, m_mode = 1;
  logic [3:0] ec = '0;

  function automatic string tag_now();
    if (flo) return "R7";
    if (fhi) return "R8";
    if (psel == 2'b11) return "R6";
    if (one) return "R2";
    return "R3/R4/R9";
  endfunction

  task automatic model_step();
    logic chg;
    chg = (one != m_mode);
    m_mode = one;
    if (flo || fhi || psel == 2'b11) begin
      logic v;
      v = fhi && !flo;
      e0 = {18{v}}; e1 = {18{v}}; eh = v; ev = v; ec = {4{v}}; es = v;
      ee = !flo; m_have = 0;
    end else begin
      ee = 0;
      if (one) begin
        es = pv; m_have = 0;
        if (pv) begin e0 = '1; e1 = rgb; eh = hs; ev = vs; ec = ctl; end
      end else if (pv && m_have && !chg) begin
        e0 = m_first; e1 = rgb; eh = hs; ev = vs; ec = ctl; es = fall; m_have = 0;
      end else begin
        es = !fall;
        if (pv) begin m_first = rgb; m_have = 1; end
        else if (chg) m_have = 0;
      end
    end
  endtask

  task automatic compare(string tag);
    logic [43:0] act, exp;
    act = {p0, p1, ho, vo, co, sc, err};
    exp = {e0, e1, eh, ev, ec, es, ee};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    string t;
    t = tag_now();
    model_step();
    @(negedge clk);
    compare(t);
  endtask

  task automatic put(input logic v, input logic [17:0] d, input logic h, input logic vv, input logic [3:0] c);
    pv = v; rgb = d; hs = h; vs = vv; ctl = c;
    tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1 after reset");

    // R2 single mode
    put(1, 18'h3F041, 1, 0, 4'hA);
    put(0, 18'h00000, 0, 0, 4'h0);
    // R3/R4 paired mode, rising edge
    one = 0; fall = 0;
    put(1, 18'h11111, 0, 0, 4'h1);
    put(1, 18'h22222, 1, 1, 4'h2);
    put(0, 18'h0, 0, 0, 4'h0);
    put(1, 18'h33333, 0, 1, 4'h3);
    put(1, 18'h04444, 1, 0, 4'h4);
    // R9 falling polarity
    fall = 1;
    put(1, 18'h15555, 0, 0, 4'h5);
    put(1, 18'h26666, 1, 1, 4'h6);
    // R5 mode change drops half pair
    put(1, 18'h37777, 0, 0, 4'h7);
    one = 1;
    put(0, 18'h0, 0, 0, 4'h0);
    one = 0;
    put(1, 18'h08888, 0, 1, 4'h8);
    put(1, 18'h19999, 1, 0, 4'h9);
    // R6 reserved code mid pair
    put(1, 18'h2AAAA, 0, 0, 4'hA);
    psel = 2'b11;
    put(1, 18'h3BBBB, 1, 1, 4'hB);
    psel = 2'b10;
    put(1, 18'h0CCCC, 0, 0, 4'hC);
    put(0, 18'h0, 0, 0, 4'h0);
    // R7 / R8 force states and priority
    fhi = 1; put(1, 18'h1DDDD, 1, 1, 4'hD);
    flo = 1; put(1, 18'h2EEEE, 1, 1, 4'hE);
    fhi = 0; flo = 0; put(0, 18'h0, 0, 0, 4'h0);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 40) == 0) one = ~one;
      if ($urandom_range(0, 60) == 0) fall = ~fall;
      psel = ($urandom_range(0, 30) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
      flo = ($urandom_range(0, 50) == 0);
      fhi = ($urandom_range(0, 40) == 0);
      put($urandom_range(0, 3) != 0, 18'($urandom), 1'($urandom), 1'($urandom), 4'($urandom));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule